// File: doc/BRIEF.md
# Serial Attenuator Word Programmer

This block sits on the host side of a three-wire serial link to a step attenuator. A client requests an attenuation in half-dB units through a valid/ready handshake. The block turns the request into an eight-bit control word, shifts that word out on a data line and a clock line, then raises a latch strobe so the attenuator commits the new setting. Every timing figure is a count of system clock cycles set by a parameter. This keeps the serial clock rate, the data setup before each rising edge, the gap before the latch, the latch width and the spacing between updates inside the attenuator's limits at any system clock frequency.

The control word is the request doubled, which is the attenuation in dB times four. The lowest and highest word bits are always zero. The largest legal request is 63 (31.5 dB). A larger request is clamped to 63 and flagged. After a word has been latched, the block holds off new requests for a guard interval, so that updates never come faster than the attenuator can follow.

Top module: `atten_ser_prog`

## Requirements
- R1: An accepted request of N half-dB units (N at most 63) is sent as the 8-bit word 2*N. The word goes out least-significant bit first, one bit per rising edge of `ser_clk`, so eight rising edges carry bit 0 through bit 7. For example, N=25 (12.5 dB) is sent as 8'b00110010.
- R2: Bit 0 (first bit sent) and bit 7 (last bit sent) of every transmitted word are low.
- R3: A request above 63 is sent as if it were 63, and `sat_flag` is high for exactly the one cycle after the accepting clock edge. A request of 63 or below leaves `sat_flag` low, and `sat_flag` is never high in any other cycle.
- R4: `ser_latch` stays low while the word is shifted and never overlaps a high `ser_clk`. After the eighth rising edge it goes high for exactly LATCH_CYC cycles, once per accepted request.
- R5: `ser_clk` is high for exactly HALF_CYC cycles and, between bits, low for exactly HALF_CYC cycles. `ser_data` changes only when `ser_clk` falls or while it is low, so it is stable for the whole high phase.
- R6: `ser_latch` rises exactly HALF_CYC+GAP_CYC cycles after the last rising edge of `ser_clk`.
- R7: `req_ready` is low from the accepting edge until exactly GUARD_CYC cycles after `ser_latch` falls. `busy` is always the complement of `req_ready`.
- R8: While reset is active, `ser_clk`, `ser_data`, `ser_latch`, `busy` and `sat_flag` are low and `req_ready` is high.
- R9: A request presented while `req_ready` is low is ignored: it produces no word and no latch pulse, and it does not lengthen the transfer in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_halfdb | input | REQ_W (8) | Requested attenuation in half-dB units |
| req_ready | output | 1 | Block can accept a request this cycle |
| ser_clk | output | 1 | Serial shift clock to the attenuator |
| ser_data | output | 1 | Serial data to the attenuator |
| ser_latch | output | 1 | Latch strobe committing the shifted word |
| busy | output | 1 | A transfer or guard interval is in progress |
| sat_flag | output | 1 | One-cycle pulse: the last accepted request was clamped |

## Verification
The assertions assume that reset is held from time zero until the first clock edges have settled the state register. They also assume that the duration parameters are all at least one, so that every phase lasts at least one cycle. Requests may arrive at any time and may carry any 8-bit value. The stimulus therefore draws full-range random values, which reach the clamp about three times in four, and it sometimes keeps `req_valid` high with a different value while a transfer is running, to exercise the ignore rule. Directed cases cover 0, 25, 63, 64 and 255.

// File: rtl/atten_pkg.sv
// Package: shared widths and sequencer state encoding for the serial
// attenuator programmer. Assumes an 8-bit word carrying a 6-bit code.
package atten_pkg;
    localparam int CODE_W = 6;
    localparam int WORD_W = CODE_W + 2;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LOW   = 3'd1,
        ST_HIGH  = 3'd2,
        ST_GAP   = 3'd3,
        ST_LATCH = 3'd4,
        ST_HOLD  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/atten_word_fmt.sv
// Module: atten_word_fmt
// Clamps a half-dB request to the largest code and frames it as the
// attenuator word {0, code, 0}. Purely combinational.
// Assumes REQ_W >= CODE_W.
module atten_word_fmt #(
    parameter int REQ_W  = 8,
    parameter int CODE_W = 6,
    parameter int WORD_W = CODE_W + 2
) (
    input  logic [REQ_W-1:0]  req_val,
    output logic [WORD_W-1:0] word,
    output logic              over
);
    localparam int MAX_CODE = (1 << CODE_W) - 1;

    logic [CODE_W-1:0] code;

    // Clamp the request and build the framed word with both guard bits low.
    always_comb begin
        over = (req_val > REQ_W'(MAX_CODE));
        code = over ? CODE_W'(MAX_CODE) : req_val[CODE_W-1:0];
        word = {1'b0, code, 1'b0};
    end
endmodule

// File: rtl/atten_tick_timer.sv
// Module: atten_tick_timer
// Loadable down counter. It saturates at zero and flags zero as done.
// The sequencer loads duration-1 on entering a phase, so a phase lasts
// exactly "duration" cycles.
module atten_tick_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    // Load on request, else count down to zero and stay there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/atten_shift_seq.sv
// Module: atten_shift_seq
// Phase sequencer. It shifts a word out LSB first with a fixed high and
// low time, waits a setup gap, pulses the latch, then holds a guard
// interval. Data changes only together with the falling clock edge.
// Assumes every duration parameter is at least 1 and start only in idle.
module atten_shift_seq
    import atten_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int HALF_CYC  = 5,
    parameter int GAP_CYC   = 2,
    parameter int LATCH_CYC = 4,
    parameter int GUARD_CYC = 4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] word,
    output logic              ser_clk,
    output logic              ser_data,
    output logic              ser_latch,
    output logic              busy
);
    localparam int MAX_A  = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
    localparam int MAX_B  = (LATCH_CYC > GUARD_CYC) ? LATCH_CYC : GUARD_CYC;
    localparam int MAX_D  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_D + 1);
    localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    seq_state_t        state, nxt;
    logic [WORD_W-1:0] shreg, shreg_nxt;
    logic [BIT_W-1:0]  bitcnt, bitcnt_nxt;
    logic              t_load, t_done;
    logic [CNT_W-1:0]  t_val;

    atten_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    // Next phase, timer reload and shift bookkeeping.
    always_comb begin
        nxt        = state;
        t_load     = 1'b0;
        t_val      = '0;
        shreg_nxt  = shreg;
        bitcnt_nxt = bitcnt;
        case (state)
            ST_IDLE: if (start) begin
                nxt        = ST_LOW;
                t_load     = 1'b1;
                t_val      = CNT_W'(HALF_CYC - 1);
                shreg_nxt  = word;
                bitcnt_nxt = '0;
            end
            ST_LOW: if (t_done) begin
                nxt    = ST_HIGH;
                t_load = 1'b1;
                t_val  = CNT_W'(HALF_CYC - 1);
            end
            ST_HIGH: if (t_done) begin
                t_load = 1'b1;
                if (bitcnt == LAST_BIT) begin
                    nxt   = ST_GAP;
                    t_val = CNT_W'(GAP_CYC - 1);
                end else begin
                    nxt        = ST_LOW;
                    t_val      = CNT_W'(HALF_CYC - 1);
                    shreg_nxt  = shreg >> 1;
                    bitcnt_nxt = bitcnt + 1'b1;
                end
            end
            ST_GAP: if (t_done) begin
                nxt    = ST_LATCH;
                t_load = 1'b1;
                t_val  = CNT_W'(LATCH_CYC - 1);
            end
            ST_LATCH: if (t_done) begin
                nxt    = ST_HOLD;
                t_load = 1'b1;
                t_val  = CNT_W'(GUARD_CYC - 1);
            end
            ST_HOLD: if (t_done) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // State, shift register and glitch-free registered line drivers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            shreg     <= '0;
            bitcnt    <= '0;
            ser_clk   <= 1'b0;
            ser_data  <= 1'b0;
            ser_latch <= 1'b0;
        end else begin
            state     <= nxt;
            shreg     <= shreg_nxt;
            bitcnt    <= bitcnt_nxt;
            ser_clk   <= (nxt == ST_HIGH);
            ser_latch <= (nxt == ST_LATCH);
            ser_data  <= ((nxt == ST_LOW) || (nxt == ST_HIGH)) ? shreg_nxt[0] : 1'b0;
        end
    end

    assign busy = (state != ST_IDLE);
endmodule

// File: rtl/atten_ser_prog.sv
// Module: atten_ser_prog (top)
// Accepts half-dB requests over valid/ready, clamps and frames them, and
// drives the three-wire serial attenuator port. It flags clamped requests
// for one cycle. Assumes HALF_CYC, GAP_CYC, LATCH_CYC and GUARD_CYC are at
// least 1 and sized for the system clock.
module atten_ser_prog
    import atten_pkg::*;
#(
    parameter int REQ_W     = 8,
    parameter int HALF_CYC  = 5,
    parameter int GAP_CYC   = 2,
    parameter int LATCH_CYC = 4,
    parameter int GUARD_CYC = 4000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [REQ_W-1:0] req_halfdb,
    output logic             req_ready,
    output logic             ser_clk,
    output logic             ser_data,
    output logic             ser_latch,
    output logic             busy,
    output logic             sat_flag
);
    logic [WORD_W-1:0] word;
    logic              over;
    logic              accept;

    atten_word_fmt #(.REQ_W(REQ_W), .CODE_W(CODE_W), .WORD_W(WORD_W)) u_fmt (
        .req_val (req_halfdb),
        .word    (word),
        .over    (over)
    );

    atten_shift_seq #(
        .WORD_W    (WORD_W),
        .HALF_CYC  (HALF_CYC),
        .GAP_CYC   (GAP_CYC),
        .LATCH_CYC (LATCH_CYC),
        .GUARD_CYC (GUARD_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .word      (word),
        .ser_clk   (ser_clk),
        .ser_data  (ser_data),
        .ser_latch (ser_latch),
        .busy      (busy)
    );

    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;

    // One-cycle clamp indication for the request just accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) sat_flag <= 1'b0;
        else        sat_flag <= accept && over;
    end
endmodule

// File: rtl/atten_ser_prog_chk.sv
// Module: atten_ser_prog_chk
// Port-level protocol checks for atten_ser_prog, attached by bind.
module atten_ser_prog_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic ser_clk,
    input logic ser_data,
    input logic ser_latch,
    input logic busy,
    input logic sat_flag
);
    // R4: latch strobe never overlaps a high shift clock.
    a_r4_latch_clock_apart: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> !ser_latch);

    // R5: data holds still across the whole high phase.
    a_r5_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R6: the shift clock is already low in the cycle the latch rises.
    a_r6_latch_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_latch) |-> (!ser_clk && !$past(ser_clk)));

    // R7: ready and busy are complementary.
    a_r7_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready != busy);

    // R7: a latch pulse only happens while the block reports busy.
    a_r7_latch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ser_latch |-> busy);

    // R3: the clamp flag follows an acceptance and lasts one cycle.
    a_r3_sat_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag |-> $past(req_valid && req_ready));
    a_r3_sat_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag |=> !sat_flag);
endmodule

bind atten_ser_prog atten_ser_prog_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ser_clk   (ser_clk),
    .ser_data  (ser_data),
    .ser_latch (ser_latch),
    .busy      (busy),
    .sat_flag  (sat_flag)
);

// File: tb/atten_ser_prog_test.sv
module atten_ser_prog_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF  = 3;
    localparam int GAP   = 2;
    localparam int LAT   = 3;
    localparam int GUARD = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [7:0] req_halfdb = 8'd0;
    logic       req_ready, ser_clk, ser_data, ser_latch, busy, sat_flag;

    int errors = 0;
    int checks = 0;

    atten_ser_prog #(
        .REQ_W(8), .HALF_CYC(HALF), .GAP_CYC(GAP),
        .LATCH_CYC(LAT), .GUARD_CYC(GUARD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_halfdb(req_halfdb),
        .req_ready(req_ready), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_latch(ser_latch), .busy(busy), .sat_flag(sat_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_word(input logic [7:0] v);
        logic [7:0] c;
        c = (v > 8'd63) ? 8'd63 : v;
        return {c[6:0], 1'b0};
    endfunction

    // Monitor state, sampled on falling edges of the system clock.
    logic [7:0] want_word = 8'd0;
    logic [7:0] rx = 8'd0;
    int nbits = 0, hi_cnt = 0, lo_cnt = 0, lat_cnt = 0;
    int since_rise = 0, since_lfall = 0, n_latch = 0, n_accept = 0;
    logic p_clk = 1'b0, p_lat = 1'b0, p_rdy = 1'b1, p_dat = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ser_clk && !p_clk) begin
                if (nbits > 0) chk(lo_cnt == HALF, "R5 low time", lo_cnt, HALF);
                chk(!ser_latch, "R4 latch low while shifting", ser_latch, 0);
                rx = {ser_data, rx[7:1]};
                nbits++;
                hi_cnt = 0;
                since_rise = 0;
            end
            if (ser_clk && p_clk)
                chk(ser_data == p_dat, "R5 data stable while high", ser_data, p_dat);
            if (!ser_clk && p_clk) begin
                chk(hi_cnt == HALF, "R5 high time", hi_cnt, HALF);
                lo_cnt = 0;
            end
            if (ser_latch && !p_lat) begin
                chk(nbits == 8, "R4 eight bits before latch", nbits, 8);
                chk(rx == want_word, "R1 word", rx, want_word);
                chk(!rx[0] && !rx[7], "R2 guard bits low", {rx[7], rx[0]}, 0);
                chk(since_rise == HALF + GAP, "R6 latch gap", since_rise, HALF + GAP);
                nbits = 0;
                lat_cnt = 0;
                n_latch++;
            end
            if (!ser_latch && p_lat) begin
                chk(lat_cnt == LAT, "R4 latch width", lat_cnt, LAT);
                since_lfall = 0;
            end
            if (req_ready && !p_rdy && n_latch > 0)
                chk(since_lfall == GUARD, "R7 guard interval", since_lfall, GUARD);
            if (ser_clk) hi_cnt++; else lo_cnt++;
            if (ser_latch) lat_cnt++;
            since_rise++;
            since_lfall++;
            p_clk = ser_clk; p_lat = ser_latch; p_rdy = req_ready; p_dat = ser_data;
        end
    end

    task automatic send(input logic [7:0] v, input bit junk);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_halfdb = v;
        want_word  = exp_word(v);
        @(negedge clk);
        n_accept++;
        req_valid = 1'b0;
        chk(sat_flag == (v > 8'd63), "R3 clamp flag", sat_flag, int'(v > 8'd63));
        chk(!req_ready && busy, "R7 ready low after accept", {req_ready, busy}, 1);
        @(negedge clk);
        chk(!sat_flag, "R3 flag one cycle", sat_flag, 0);
        if (junk) begin
            req_valid  = 1'b1;
            req_halfdb = ~v;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                chk(!req_ready, "R9 ignored while busy", req_ready, 0);
            end
            req_valid = 1'b0;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [31:0] r;
        r = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        chk(!ser_clk && !ser_data && !ser_latch && !busy && !sat_flag && req_ready,
            "R8 reset state",
            {ser_clk, ser_data, ser_latch, busy, sat_flag, req_ready}, 1);
        rst_n = 1'b1;
        send(8'd25, 1'b0);    // R1 12.5 dB example
        send(8'd0, 1'b0);
        send(8'd63, 1'b0);
        send(8'd64, 1'b1);    // R3 just above the limit
        send(8'd255, 1'b0);
        send(8'd42, 1'b1);    // R9 junk while busy
        for (int k = 0; k < 40; k++) begin
            r = $urandom;
            send(r[7:0], r[8]);
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(n_latch == n_accept, "R9 one latch per accepted request", n_latch, n_accept);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule